// File: doc/BRIEF.md
# Three-Path Graphics Packet Arbiter

This block collects packet streams from three producers (a vector coprocessor on path 1, a vector-interface FIFO on path 2 and a DMA channel on path 3) and forwards one of them at a time to a single rasterizer input. Every port uses a valid/ready handshake. One data word moves per clock.

A packet starts with a header word. The low `CNT_W` bits of the header hold a payload count N, and bit `CNT_W` holds a final-packet flag. N payload words follow the header, so a packet with N = 0 is a single header word. The arbiter decodes every header and counts down the payload. This lets it find each packet end and change the grant only there, so a transfer in flight is never cut.

Paths 1 and 2 keep the grant across packets until a packet that carries the final flag ends. Path 3 gives up the grant at every packet end, so a train of path 3 packets is never forwarded as one lump. A hold input blocks path 3 from being granted while the coprocessor is busy. Priority is fixed: path 1 first, then path 2, then path 3. Status outputs show the granted path and the registered hold state.

Top module: `gfx_path_arbiter`

## Requirements
- R1: After reset, `snk_valid` is 0, `stat_path` is 0 (idle) and every bit of `src_ready` is 0.
- R2: A packet is a header word followed by N payload words, where N is header bits [CNT_W-1:0]. N = 0 gives a header-only packet. Each word reaches `snk_data` unchanged and in order, and `snk_src` gives the path number (1, 2 or 3).
- R3: When the arbiter is idle, it grants the lowest-numbered path that is requesting and eligible (1 before 2 before 3) on the clock after the request is seen.
- R4: Once a path holds the grant, the grant does not move before that path's packet ends. The other paths see `src_ready` low for the whole packet.
- R5: On paths 1 and 2, a packet whose header bit CNT_W is 0 keeps the grant for that path's next packet. A packet with bit CNT_W set ends the transfer.
- R6: Path 3 gives up the grant at the end of every packet, whatever its flag bit holds.
- R7: In the cycle a transfer ends, the next grant goes to the highest-priority requesting, eligible path among the other two. If neither requests, the arbiter goes idle. The finishing path is never granted again directly.
- R8: While `p3_hold` is high, path 3 is not granted. A path 3 packet already in progress still completes.
- R9: While `snk_valid` is high and `snk_ready` is low, `snk_data` and `snk_src` hold, the grant holds and `src_ready` is all zero.
- R10: `snk_valid` is never high with `snk_src` equal to 0, and at most one bit of `src_ready` is high.
- R11: `stat_path` shows the grant (0 idle, 1 to 3 for a path). `stat_masked` shows `p3_hold` delayed by one clock.
- R12: With `snk_ready` held high, a granted packet streams one word per clock, with no gap, up to the largest count `CNT_W` allows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_valid | input | 3 | Per-path valid, bit 0 = path 1 |
| src_ready | output | 3 | Per-path ready, bit 0 = path 1 |
| src_data | input | 3*DATA_W | Per-path word, path 1 in the lowest slice |
| p3_hold | input | 1 | Blocks path 3 from being granted |
| snk_valid | output | 1 | Output word valid |
| snk_ready | input | 1 | Sink accepts output word |
| snk_data | output | DATA_W | Output word |
| snk_src | output | 2 | Path that supplied the output word |
| stat_path | output | 2 | Granted path, 0 = idle |
| stat_masked | output | 1 | Registered path 3 hold state |

## Verification
The bench builds the arbiter with `DATA_W` = 32 and `CNT_W` = 6. The final flag then sits at bit 6, and a tag in the upper header bits marks each word's path and packet. The narrow count puts the largest packet (63 payload words) within a short run, so gap-free streaming can be checked across a whole maximum-length packet. The same small widths make it cheap to mix zero-count packets, multi-packet transfers, late arrivals during a packet, hold changes during a packet and periodic sink stalls.

// File: rtl/gfx_arb_pkg.sv
package gfx_arb_pkg;
  localparam int NUM_PATHS = 3;
  localparam int PATH_W    = 2;

  typedef enum logic [PATH_W-1:0] {
    PATH_NONE = 2'd0,
    PATH_ONE  = 2'd1,
    PATH_TWO  = 2'd2,
    PATH_THR  = 2'd3
  } path_e;
endpackage

// File: rtl/gfx_arb_pick.sv
module gfx_arb_pick
  import gfx_arb_pkg::*;
#(
  parameter int NP = NUM_PATHS
) (
  input  logic [NP-1:0] req,
  output path_e         win
);
  // Path 1 (bit 0) has the highest priority. The scan runs downward so the
  // lowest index that is requesting is the last one written.
  always_comb begin
    win = PATH_NONE;
    for (int i = NP - 1; i >= 0; i--) begin
      if (req[i]) win = path_e'(i + 1);
    end
  end
endmodule

// File: rtl/gfx_arb_track.sv
module gfx_arb_track #(
  parameter int CNT_W = 15
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           beat,
  input  logic [CNT_W:0] hdr_word,
  output logic           pkt_end,
  output logic           pkt_last
);
  logic             in_pay;
  logic [CNT_W-1:0] remain;
  logic             last_q;
  logic [CNT_W-1:0] hdr_cnt;

  assign hdr_cnt = hdr_word[CNT_W-1:0];

  always_comb begin
    if (!in_pay) begin
      pkt_end  = beat && (hdr_cnt == '0);
      pkt_last = hdr_word[CNT_W];
    end else begin
      pkt_end  = beat && (remain == CNT_W'(1));
      pkt_last = last_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      in_pay <= 1'b0;
      remain <= '0;
      last_q <= 1'b0;
    end else if (beat) begin
      if (!in_pay) begin
        in_pay <= (hdr_cnt != '0);
        remain <= hdr_cnt;
        last_q <= hdr_word[CNT_W];
      end else begin
        remain <= remain - CNT_W'(1);
        if (remain == CNT_W'(1)) in_pay <= 1'b0;
      end
    end
  end

  // R2: while payload words are due, the remaining count is never zero
  p_payload_nonzero_r2: assert property (@(posedge clk) disable iff (rst)
    in_pay |-> (remain != '0));
endmodule

// File: rtl/gfx_arb_out.sv
module gfx_arb_out
  import gfx_arb_pkg::*;
#(
  parameter int DATA_W = 128
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [DATA_W-1:0] din,
  input  path_e             src_in,
  input  logic              snk_ready,
  output logic              snk_valid,
  output logic [DATA_W-1:0] snk_data,
  output path_e             snk_src,
  output logic              can_take
);
  assign can_take = !snk_valid || snk_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      snk_valid <= 1'b0;
      snk_src   <= PATH_NONE;
      snk_data  <= '0;
    end else if (can_take) begin
      snk_valid <= load;
      snk_src   <= load ? src_in : PATH_NONE;
      if (load) snk_data <= din;
    end
  end

  p_stall_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (snk_valid && !snk_ready) |=> (snk_valid && $stable(snk_data) && $stable(snk_src)));

  p_valid_tagged_r10: assert property (@(posedge clk) disable iff (rst)
    snk_valid |-> (snk_src != PATH_NONE));
endmodule

// File: rtl/gfx_path_arbiter.sv
module gfx_path_arbiter
  import gfx_arb_pkg::*;
#(
  parameter int DATA_W = 128,
  parameter int CNT_W  = 15
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [NUM_PATHS-1:0]        src_valid,
  output logic [NUM_PATHS-1:0]        src_ready,
  input  logic [NUM_PATHS*DATA_W-1:0] src_data,
  input  logic                        p3_hold,
  output logic                        snk_valid,
  input  logic                        snk_ready,
  output logic [DATA_W-1:0]           snk_data,
  output logic [PATH_W-1:0]           snk_src,
  output logic [PATH_W-1:0]           stat_path,
  output logic                        stat_masked
);
  localparam int HDR_W = CNT_W + 1;

  path_e                grant;
  path_e                grant_n;
  path_e                pick_idle;
  path_e                pick_end;
  path_e                out_src;
  logic [DATA_W-1:0]    sel_data;
  logic [NUM_PATHS-1:0] cur_vec;
  logic [NUM_PATHS-1:0] elig;
  logic                 can_take;
  logic                 take;
  logic                 pkt_end;
  logic                 pkt_last;
  logic                 xfer_end;
  logic                 masked_q;

  // One-hot view of the grant and the per-path data select
  always_comb begin
    sel_data = '0;
    cur_vec  = '0;
    for (int i = 0; i < NUM_PATHS; i++) begin
      if (grant == path_e'(i + 1)) begin
        cur_vec[i] = 1'b1;
        sel_data   = src_data[i*DATA_W +: DATA_W];
      end
    end
  end

  assign src_ready = can_take ? cur_vec : '0;
  assign take      = |(src_valid & src_ready);

  // Path 3 is eligible only when no hold is applied
  assign elig = {~p3_hold, {(NUM_PATHS-1){1'b1}}};

  gfx_arb_pick #(.NP(NUM_PATHS)) u_pick_idle (
    .req (src_valid & elig),
    .win (pick_idle)
  );

  gfx_arb_pick #(.NP(NUM_PATHS)) u_pick_end (
    .req (src_valid & elig & ~cur_vec),
    .win (pick_end)
  );

  gfx_arb_track #(.CNT_W(CNT_W)) u_track (
    .clk      (clk),
    .rst      (rst),
    .beat     (take),
    .hdr_word (sel_data[HDR_W-1:0]),
    .pkt_end  (pkt_end),
    .pkt_last (pkt_last)
  );

  // Path 3 yields at every packet end; paths 1 and 2 at a flagged packet end
  assign xfer_end = pkt_end && ((grant == PATH_THR) || pkt_last);

  always_comb begin
    if (grant == PATH_NONE)  grant_n = pick_idle;
    else if (xfer_end)       grant_n = pick_end;
    else                     grant_n = grant;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      grant    <= PATH_NONE;
      masked_q <= 1'b0;
    end else begin
      grant    <= grant_n;
      masked_q <= p3_hold;
    end
  end

  gfx_arb_out #(.DATA_W(DATA_W)) u_out (
    .clk       (clk),
    .rst       (rst),
    .load      (take),
    .din       (sel_data),
    .src_in    (grant),
    .snk_ready (snk_ready),
    .snk_valid (snk_valid),
    .snk_data  (snk_data),
    .snk_src   (out_src),
    .can_take  (can_take)
  );

  assign snk_src     = out_src;
  assign stat_path   = grant;
  assign stat_masked = masked_q;

  p_no_preempt_r4: assert property (@(posedge clk) disable iff (rst)
    (grant != PATH_NONE && !xfer_end) |=> (grant == $past(grant)));

  p_hold_blocks_r8: assert property (@(posedge clk) disable iff (rst)
    (p3_hold && grant != PATH_THR) |=> (grant != PATH_THR));

  p_stall_grant_r9: assert property (@(posedge clk) disable iff (rst)
    (grant != PATH_NONE && snk_valid && !snk_ready) |=> $stable(grant));

  p_ready_onehot_r10: assert property (@(posedge clk) disable iff (rst)
    $onehot0(src_ready));

  p_p3_yield_r6: assert property (@(posedge clk) disable iff (rst)
    (grant == PATH_THR && pkt_end) |=> (grant != PATH_THR));
endmodule

// File: tb/sim_gfx_path_arbiter.sv
`timescale 1ns/1ps
module sim_gfx_path_arbiter;
  localparam int DW = 32;
  localparam int CW = 6;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [2:0]    vld = '0;
  logic [2:0]    rdy_o;
  logic [DW-1:0] dat [3];
  logic [3*DW-1:0] dat_flat;
  logic          hold = 1'b0;
  logic          snk_valid;
  logic          snk_rdy = 1'b0;
  logic [DW-1:0] snk_data;
  logic [1:0]    snk_src;
  logic [1:0]    stat_path;
  logic          stat_masked;

  always #2.5 clk = ~clk;

  always_comb begin
    for (int p = 0; p < 3; p++) dat_flat[p*DW +: DW] = dat[p];
  end

  gfx_path_arbiter #(.DATA_W(DW), .CNT_W(CW)) u0 (
    .clk(clk), .rst(rst), .src_valid(vld), .src_ready(rdy_o), .src_data(dat_flat),
    .p3_hold(hold), .snk_valid(snk_valid), .snk_ready(snk_rdy), .snk_data(snk_data),
    .snk_src(snk_src), .stat_path(stat_path), .stat_masked(stat_masked)
  );

  // Source models and sink log
  logic [DW-1:0] src_mem [3][256];
  int src_n [3];
  int src_idx [3];
  int start_at [3];
  int pk_start [3][8];
  int pk_len [3][8];
  int pk_cnt [3];
  bit acc [3];
  int cyc = 0;
  bit stall = 0;
  bit bp = 0;
  logic [DW-1:0] log_d [1024];
  logic [1:0]    log_s [1024];
  int            log_c [1024];
  int log_n = 0;
  logic [DW-1:0] exp_d [1024];
  logic [1:0]    exp_s [1024];
  int exp_n = 0;
  int n_chk = 0;
  int n_bad = 0;

  always @(negedge clk) begin
    cyc = cyc + 1;
    for (int p = 0; p < 3; p++) begin
      if (acc[p]) src_idx[p] = src_idx[p] + 1;
      if (!rst && src_idx[p] < src_n[p] && cyc >= start_at[p]) begin
        vld[p] = 1'b1;
        dat[p] = src_mem[p][src_idx[p]];
      end else begin
        vld[p] = 1'b0;
        dat[p] = '0;
      end
    end
    snk_rdy = stall ? 1'b0 : (bp ? ((cyc % 3) != 1) : 1'b1);
    #1;
    for (int p = 0; p < 3; p++) acc[p] = vld[p] && rdy_o[p];
    if (snk_valid && snk_rdy) begin
      log_d[log_n] = snk_data;
      log_s[log_n] = snk_src;
      log_c[log_n] = cyc;
      log_n = log_n + 1;
    end
  end

  initial begin
    int wd = 0;
    forever begin
      @(posedge clk);
      wd++;
      if (wd > 150000) begin
        $display("FAIL watchdog expired: act=%0d cycles exp<=150000", wd);
        n_bad++;
        n_chk++;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
      end
    end
  end

  task automatic chk(input bit ok, input string rq, input longint act, input longint expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: act=%0h exp=%0h", rq, act, expv);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    hold = 1'b0;
    stall = 0;
    bp = 0;
    log_n = 0;
    exp_n = 0;
    for (int p = 0; p < 3; p++) begin
      src_n[p] = 0; src_idx[p] = 0; start_at[p] = 0; pk_cnt[p] = 0; acc[p] = 0;
    end
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
  endtask

  // Header: tag | flag at bit CW | count in bits [CW-1:0]
  task automatic add_pkt(input int p, input int cnt, input bit last);
    int k = pk_cnt[p];
    pk_start[p][k] = src_n[p];
    pk_len[p][k] = cnt + 1;
    src_mem[p][src_n[p]] = {4'(p + 1), 4'(k), 16'hC0DE, 1'b0, last, 6'(cnt)};
    src_n[p]++;
    for (int b = 0; b < cnt; b++) begin
      src_mem[p][src_n[p]] = {4'(p + 1), 4'(k), 16'(b), 8'h5A};
      src_n[p]++;
    end
    pk_cnt[p]++;
  endtask

  task automatic exp_pkt(input int p, input int k);
    for (int b = 0; b < pk_len[p][k]; b++) begin
      exp_d[exp_n] = src_mem[p][pk_start[p][k] + b];
      exp_s[exp_n] = 2'(p + 1);
      exp_n++;
    end
  endtask

  task automatic run_done(input string rq);
    int t = 0;
    while ((log_n < exp_n || src_idx[0] < src_n[0] || src_idx[1] < src_n[1] ||
            src_idx[2] < src_n[2]) && t < 3000) begin
      @(posedge clk);
      t++;
    end
    repeat (4) @(posedge clk);
    #1;
    chk(t < 3000, {rq, " finish"}, t, 3000);
    chk(log_n == exp_n, {rq, " word count"}, log_n, exp_n);
    for (int i = 0; i < exp_n && i < log_n; i++) begin
      chk(log_d[i] == exp_d[i] && log_s[i] == exp_s[i], {rq, " word"},
          {log_s[i], log_d[i]}, {exp_s[i], exp_d[i]});
    end
  endtask

  task automatic t_reset();
    do_reset();
    @(negedge clk); #2;
    chk(snk_valid == 1'b0, "R1 snk_valid", snk_valid, 0);
    chk(stat_path == 2'd0, "R1 stat_path", stat_path, 0);
    chk(rdy_o == 3'b000, "R1 src_ready", rdy_o, 0);
  endtask

  task automatic t_framing();
    do_reset();
    add_pkt(1, 3, 1'b0);
    add_pkt(1, 0, 1'b1);
    exp_pkt(1, 0); exp_pkt(1, 1);
    run_done("R2 R5 framing and zero count");
  endtask

  task automatic t_priority();
    do_reset();
    add_pkt(2, 2, 1'b1);
    add_pkt(1, 1, 1'b1);
    add_pkt(0, 2, 1'b1);
    exp_pkt(0, 0); exp_pkt(1, 0); exp_pkt(2, 0);
    run_done("R3 R7 priority order");
  endtask

  task automatic t_no_preempt();
    do_reset();
    add_pkt(2, 6, 1'b1);
    add_pkt(0, 1, 1'b1);
    start_at[0] = cyc + 5;
    exp_pkt(2, 0); exp_pkt(0, 0);
    while (log_n < 3) @(posedge clk);
    #1;
    chk(vld[0] == 1'b1 && rdy_o[0] == 1'b0, "R4 late path 1 stalled", {vld[0], rdy_o[0]}, 2'b10);
    run_done("R4 no preemption");
  endtask

  task automatic t_transfer_hold();
    do_reset();
    add_pkt(0, 2, 1'b0);
    add_pkt(0, 1, 1'b1);
    add_pkt(1, 1, 1'b1);
    exp_pkt(0, 0); exp_pkt(0, 1); exp_pkt(1, 0);
    run_done("R5 multi-packet transfer");
  endtask

  task automatic t_p3_split();
    do_reset();
    add_pkt(2, 3, 1'b0);
    add_pkt(2, 1, 1'b0);
    add_pkt(1, 0, 1'b1);
    start_at[1] = cyc + 4;
    exp_pkt(2, 0); exp_pkt(1, 0); exp_pkt(2, 1);
    run_done("R6 path 3 split at packet end");
  endtask

  task automatic t_no_regrant();
    do_reset();
    add_pkt(1, 1, 1'b1);
    add_pkt(1, 1, 1'b1);
    add_pkt(2, 2, 1'b1);
    exp_pkt(1, 0); exp_pkt(2, 0); exp_pkt(1, 1);
    run_done("R7 finishing path not regranted");
  endtask

  task automatic t_mask_idle();
    do_reset();
    hold = 1'b1;
    add_pkt(2, 1, 1'b1);
    repeat (10) @(posedge clk);
    #1;
    chk(log_n == 0, "R8 held path 3 forwards nothing", log_n, 0);
    chk(stat_path == 2'd0, "R11 stat_path idle while held", stat_path, 0);
    chk(stat_masked == 1'b1, "R11 stat_masked", stat_masked, 1);
    hold = 1'b0;
    @(posedge clk); #1;
    chk(stat_masked == 1'b0, "R11 stat_masked cleared", stat_masked, 0);
    exp_pkt(2, 0);
    run_done("R8 release hold");
  endtask

  task automatic t_mask_mid();
    do_reset();
    add_pkt(2, 5, 1'b1);
    add_pkt(2, 1, 1'b1);
    exp_pkt(2, 0); exp_pkt(2, 1);
    while (log_n < 2) @(posedge clk);
    #1 hold = 1'b1;
    repeat (15) @(posedge clk);
    #1;
    chk(log_n == 6, "R8 packet in progress completes, next held", log_n, 6);
    hold = 1'b0;
    run_done("R8 hold during packet");
  endtask

  task automatic t_stall();
    logic [DW-1:0] d0;
    do_reset();
    add_pkt(1, 3, 1'b1);
    add_pkt(0, 4, 1'b1);
    start_at[0] = cyc + 4;
    exp_pkt(1, 0); exp_pkt(0, 0);
    while (!snk_valid) @(posedge clk);
    #1 stall = 1;
    repeat (2) @(posedge clk);
    #1 d0 = snk_data;
    repeat (4) @(posedge clk);
    #1;
    chk(snk_valid && snk_data == d0, "R9 data held during stall", snk_data, d0);
    chk(stat_path == 2'd2, "R9 R11 grant held during stall", stat_path, 2);
    chk(rdy_o == 3'b000, "R9 src_ready low during stall", rdy_o, 0);
    stall = 0;
    bp = 1;
    run_done("R9 R10 backpressure");
  endtask

  task automatic t_max();
    do_reset();
    add_pkt(1, 63, 1'b1);
    exp_pkt(1, 0);
    run_done("R12 max count");
    chk(log_n == 64 && (log_c[63] - log_c[0]) == 63, "R12 one word per clock",
        log_c[63] - log_c[0], 63);
  endtask

  initial begin
    for (int p = 0; p < 3; p++) dat[p] = '0;
    t_reset();
    t_framing();
    t_priority();
    t_no_preempt();
    t_transfer_hold();
    t_p3_split();
    t_no_regrant();
    t_mask_idle();
    t_mask_mid();
    t_stall();
    t_max();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule